// File: doc/BRIEF.md
# Presettable Modulus-N Reload Counter

A four-bit synchronous binary counter with a parallel preset path. By default it steps through all sixteen codes and wraps from 1111 to 0000. A built-in decode watches for one chosen terminal code. When that code appears, the counter reloads the value on its preset inputs. With the preset inputs tied to 0001 this turns the modulus-16 core into a shorter repeating sequence.

A mode pin selects how the reload and the external load behave. In clocked mode the load takes effect at the next rising edge. In that mode a terminal code of 1100 stays visible for a full cycle, so the loop has twelve states. In immediate mode the load overrides the output combinationally. In that mode the terminal code never shows at the output, and the same wiring gives an eleven-state loop. The terminal code is a parameter, so any modulus from 2 to 16 can be built.

Top module: `modn_reload_counter`

## Requirements
- R1: While `rst_n` is low the count reads 0000 and `term_hit` is low, whatever the load, enable and mode inputs are doing. The reset is asynchronous. After release, two rising edges pass before counting resumes.
- R2: When no load is pending and `cnt_en` is high, each rising edge adds one to the count, and 1111 is followed by 0000.
- R3: When no load is pending and `cnt_en` is low, the count keeps its value across rising edges.
- R4: When `async_mode` is 0 and `load_n` is low, the next rising edge places `preset_val` on the count, even when `cnt_en` is high.
- R5: When `async_mode` is 1 and `load_n` is low, the count equals `preset_val` at once, with no clock edge needed. It stays there for as long as `load_n` remains low.
- R6: With `async_mode` 0, the terminal code 1100 and a preset of 0001, the count repeats 0001 through 1100, which is twelve states. The reload from 1100 happens at the next edge even when `cnt_en` is low.
- R7: With `async_mode` 1, the terminal code 1100 and a preset of 0001, the count repeats 0001 through 1011, which is eleven states. The value 1100 never appears on the count.
- R8: `term_hit` is high exactly while the internal state equals the terminal code. In clocked mode this is the cycle in which the count reads 1100. In immediate mode it is the cycle after 1011, in which the count already shows the preset.
- R9: Reset overrides both loading and counting.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Rising-edge clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside |
| load_n | input | 1 | Active-low parallel load request |
| preset_val | input | 4 | Value for parallel load and for self-reload |
| cnt_en | input | 1 | Active-high count enable |
| async_mode | input | 1 | 0: clocked load, 1: immediate load |
| count | output | 4 | Current count |
| term_hit | output | 1 | Terminal-state decode of the internal register |

## Verification
Two things can fall on the same cycle: a load request and a counting edge. In clocked mode there is also the self-reload, which can meet a low enable. The bench holds `load_n` low with `cnt_en` high and expects the preset rather than an increment. It drops `cnt_en` exactly when the count sits on 1100 and expects 0001 at the next edge. In immediate mode it samples the output between edges, so it can show that the preset arrives without a clock and that 1100 is never observed while the eleven-state loop runs.

// File: rtl/modn_pkg.sv
package modn_pkg;

  // Load behaviour selected by the mode pin
  typedef enum logic {
    LD_CLOCKED   = 1'b0,
    LD_IMMEDIATE = 1'b1
  } load_style_e;

  localparam int unsigned MODN_DEF_W    = 4;
  localparam int unsigned MODN_DEF_TERM = 12;

endpackage

// File: rtl/modn_rst_sync.sv
module modn_rst_sync #(
  parameter int unsigned STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  output logic rst_s_n
);

  logic [STAGES-1:0] sh_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      sh_q <= '0;
    end else begin
      sh_q <= {sh_q[STAGES-2:0], 1'b1};
    end
  end

  assign rst_s_n = sh_q[STAGES-1];

endmodule

// File: rtl/modn_term_decode.sv
module modn_term_decode #(
  parameter int unsigned WIDTH      = 4,
  parameter int unsigned TERM_STATE = 12,
  parameter bit          ENABLE     = 1'b1
) (
  input  logic [WIDTH-1:0] state_q,
  output logic             hit
);

  localparam logic [WIDTH-1:0] TERM_V = WIDTH'(TERM_STATE);

  generate
    if (ENABLE) begin : g_dec
      assign hit = (state_q == TERM_V);
    end else begin : g_nodec
      assign hit = 1'b0;
    end
  endgenerate

endmodule

// File: rtl/modn_next_state.sv
module modn_next_state
  import modn_pkg::*;
#(
  parameter int unsigned WIDTH = 4
) (
  input  logic [WIDTH-1:0] state_q,
  input  logic [WIDTH-1:0] preset,
  input  logic             load_req_n,
  input  logic             cnt_en,
  input  load_style_e      style,
  input  logic             term_hit,
  input  logic             run,
  output logic [WIDTH-1:0] view,
  output logic [WIDTH-1:0] state_d,
  output logic             upd
);

  localparam logic [WIDTH-1:0] ONE = WIDTH'(1);

  logic ext_ld;
  logic any_ld;
  logic ovr;
  logic clk_ld;

  always_comb begin
    ext_ld = ~load_req_n;
    any_ld = ext_ld | term_hit;
    // immediate style: output follows the preset without waiting for an edge
    ovr    = run & (style == LD_IMMEDIATE) & any_ld;
    clk_ld = (style == LD_CLOCKED) & any_ld;
    view   = ovr ? preset : state_q;
    // a held external load pins the register; a self-reload in immediate
    // style has already been applied to view, so counting continues from it
    if (ext_ld || clk_ld) begin
      state_d = preset;
    end else if (cnt_en) begin
      state_d = view + ONE;
    end else begin
      state_d = view;
    end
    upd = any_ld | cnt_en;
  end

endmodule

// File: rtl/modn_state_reg.sv
module modn_state_reg #(
  parameter int unsigned WIDTH = 4
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             en,
  input  logic [WIDTH-1:0] d,
  output logic [WIDTH-1:0] q
);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      q <= '0;
    end else if (en) begin
      q <= d;
    end
  end

endmodule

// File: rtl/modn_reload_counter.sv
module modn_reload_counter
  import modn_pkg::*;
#(
  parameter int unsigned WIDTH       = MODN_DEF_W,
  parameter int unsigned TERM_STATE  = MODN_DEF_TERM,
  parameter bit          AUTO_RELOAD = 1'b1,
  parameter int unsigned SYNC_STAGES = 2
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             load_n,
  input  logic [WIDTH-1:0] preset_val,
  input  logic             cnt_en,
  input  logic             async_mode,
  output logic [WIDTH-1:0] count,
  output logic             term_hit
);

  logic             rst_s_n;
  logic [WIDTH-1:0] state_q;
  logic [WIDTH-1:0] state_d;
  logic [WIDTH-1:0] view;
  logic             upd;
  logic             hit;
  load_style_e      style;

  assign style = load_style_e'(async_mode);

  modn_rst_sync #(.STAGES(SYNC_STAGES)) rst_sync_i (
    .clk     (clk),
    .rst_n   (rst_n),
    .rst_s_n (rst_s_n)
  );

  modn_term_decode #(
    .WIDTH      (WIDTH),
    .TERM_STATE (TERM_STATE),
    .ENABLE     (AUTO_RELOAD)
  ) term_i (
    .state_q (state_q),
    .hit     (hit)
  );

  modn_next_state #(.WIDTH(WIDTH)) nxt_i (
    .state_q    (state_q),
    .preset     (preset_val),
    .load_req_n (load_n),
    .cnt_en     (cnt_en),
    .style      (style),
    .term_hit   (hit),
    .run        (rst_s_n),
    .view       (view),
    .state_d    (state_d),
    .upd        (upd)
  );

  modn_state_reg #(.WIDTH(WIDTH)) reg_i (
    .clk   (clk),
    .rst_n (rst_s_n),
    .en    (upd),
    .d     (state_d),
    .q     (state_q)
  );

  assign count    = view;
  assign term_hit = hit;

endmodule

// File: rtl/modn_reload_counter_chk.sv
module modn_reload_counter_chk #(
  parameter int unsigned WIDTH       = 4,
  parameter int unsigned TERM_STATE  = 12,
  parameter bit          AUTO_RELOAD = 1'b1
) (
  input logic             clk,
  input logic             rst_s_n,
  input logic             load_n,
  input logic [WIDTH-1:0] preset_val,
  input logic             cnt_en,
  input logic             async_mode,
  input logic [WIDTH-1:0] count,
  input logic             term_hit
);

  localparam logic [WIDTH-1:0] TERM_V = WIDTH'(TERM_STATE);
  localparam logic [WIDTH-1:0] ONE    = WIDTH'(1);

  // R2
  step_up_chk: assert property (@(posedge clk) disable iff (!rst_s_n)
    (!async_mode && load_n && cnt_en && !term_hit)
      |=> (async_mode || count == $past(count) + ONE));

  // R3
  hold_chk: assert property (@(posedge clk) disable iff (!rst_s_n)
    (!async_mode && load_n && !cnt_en && !term_hit)
      |=> (async_mode || $stable(count)));

  // R4
  clocked_load_chk: assert property (@(posedge clk) disable iff (!rst_s_n)
    (!async_mode && !load_n)
      |=> (async_mode || count == $past(preset_val)));

  // R5
  immediate_load_chk: assert property (@(posedge clk) disable iff (!rst_s_n)
    (async_mode && !load_n) |-> (count == preset_val));

  // R7
  skip_term_chk: assert property (@(posedge clk) disable iff (!rst_s_n)
    (AUTO_RELOAD && async_mode && preset_val != TERM_V) |-> (count != TERM_V));

  // R8
  term_flag_chk: assert property (@(posedge clk) disable iff (!rst_s_n)
    (!async_mode && term_hit) |-> (count == TERM_V));

endmodule

bind modn_reload_counter modn_reload_counter_chk #(
  .WIDTH       (WIDTH),
  .TERM_STATE  (TERM_STATE),
  .AUTO_RELOAD (AUTO_RELOAD)
) chk_i (
  .clk        (clk),
  .rst_s_n    (rst_s_n),
  .load_n     (load_n),
  .preset_val (preset_val),
  .cnt_en     (cnt_en),
  .async_mode (async_mode),
  .count      (count),
  .term_hit   (term_hit)
);

// File: tb/modn_reload_counter_tb_top.sv
module modn_reload_counter_tb_top;

  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       load_n = 1'b1;
  logic [3:0] preset_val = 4'd0;
  logic       cnt_en = 1'b0;
  logic       async_mode = 1'b0;
  logic [3:0] count;
  logic       term_hit;

  int n_chk = 0;
  int n_bad = 0;
  bit done  = 1'b0;

  always #10 clk = ~clk;

  modn_reload_counter dut_i (
    .clk        (clk),
    .rst_n      (rst_n),
    .load_n     (load_n),
    .preset_val (preset_val),
    .cnt_en     (cnt_en),
    .async_mode (async_mode),
    .count      (count),
    .term_hit   (term_hit)
  );

  task automatic chk(input string req, input logic [3:0] act, input logic [3:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s: actual %0d expected %0d at %0t", req, act, exp, $time);
    end
  endtask

  // one rising edge, then settle at the falling edge
  task automatic tick();
    @(posedge clk);
    @(negedge clk);
  endtask

  task automatic t_reset();
    async_mode = 1'b1; load_n = 1'b0; cnt_en = 1'b1; preset_val = 4'd7;
    tick(); tick();
    chk("R1 count in reset", count, 4'd0);
    chk("R1 term_hit in reset", {3'b0, term_hit}, 4'd0);
    chk("R9 reset beats load and count", count, 4'd0);
    async_mode = 1'b0; load_n = 1'b1; cnt_en = 1'b0;
    rst_n = 1'b1;
    tick(); tick(); tick();
    chk("R1 count after release", count, 4'd0);
  endtask

  task automatic t_clocked_load_count();
    async_mode = 1'b0; preset_val = 4'd5; load_n = 1'b0; cnt_en = 1'b1;
    #1 chk("R4 no change before edge", count, 4'd0);
    tick();
    chk("R4 load beats count", count, 4'd5);
    load_n = 1'b1;
    tick(); tick(); tick();
    chk("R2 three steps", count, 4'd8);
  endtask

  task automatic t_hold();
    cnt_en = 1'b0;
    tick(); tick();
    chk("R3 hold", count, 4'd8);
  endtask

  task automatic t_wrap();
    preset_val = 4'd13; load_n = 1'b0; cnt_en = 1'b0;
    tick();
    load_n = 1'b1; cnt_en = 1'b1;
    tick(); chk("R2 step to 14", count, 4'd14);
    tick(); chk("R2 step to 15", count, 4'd15);
    tick(); chk("R2 wrap to 0", count, 4'd0);
    cnt_en = 1'b0;
  endtask

  task automatic t_mod12();
    logic [3:0] exp;
    preset_val = 4'd1; load_n = 1'b0;
    tick();
    load_n = 1'b1; cnt_en = 1'b1;
    exp = 4'd1;
    chk("R6 start", count, exp);
    for (int i = 0; i < 23; i++) begin
      tick();
      exp = (exp == 4'd12) ? 4'd1 : exp + 4'd1;
      chk("R6 sequence", count, exp);
      chk("R8 flag clocked", {3'b0, term_hit}, {3'b0, (exp == 4'd12)});
    end
    cnt_en = 1'b0;
    tick();
    chk("R6 reload with enable low", count, 4'd1);
    tick();
    chk("R3 hold after reload", count, 4'd1);
  endtask

  task automatic t_immediate_load();
    async_mode = 1'b1; cnt_en = 1'b0; preset_val = 4'd9;
    #2 load_n = 1'b0;
    #1 chk("R5 immediate preset", count, 4'd9);
    tick();
    chk("R5 held across edge", count, 4'd9);
    cnt_en = 1'b1;
    tick();
    chk("R5 held while enabled", count, 4'd9);
    load_n = 1'b1; cnt_en = 1'b0;
    #1 chk("R5 stays after release", count, 4'd9);
    tick();
    chk("R3 hold immediate mode", count, 4'd9);
  endtask

  task automatic t_mod11();
    logic [3:0] exp;
    logic       prev11;
    preset_val = 4'd1;
    #2 load_n = 1'b0;
    #1 chk("R7 preset visible", count, 4'd1);
    tick();
    load_n = 1'b1; cnt_en = 1'b1;
    exp = 4'd1;
    for (int i = 0; i < 25; i++) begin
      prev11 = (exp == 4'd11);
      tick();
      exp = (exp == 4'd11) ? 4'd1 : exp + 4'd1;
      chk("R7 sequence", count, exp);
      if (count == 4'd12) chk("R7 terminal seen", count, 4'd1);
      chk("R8 flag immediate", {3'b0, term_hit}, {3'b0, prev11});
    end
    cnt_en = 1'b0;
  endtask

  initial begin
    t_reset();
    t_clocked_load_count();
    t_hold();
    t_wrap();
    t_mod12();
    t_immediate_load();
    t_mod11();
    done = 1'b1;
    $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end

  initial begin
    repeat (5000) @(posedge clk);
    if (!done) begin
      n_chk++;
      n_bad++;
      $display("FAIL watchdog: actual hung expected done");
      $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
      $finish;
    end
  end

endmodule